// File: doc/BRIEF.md
# BCD Seven-Segment Latch Decoder

This block turns one 4-bit binary-coded decimal digit into the seven segment lines of a numeric readout. A pass-enable input chooses between tracking the incoming code and holding the last code it saw. A blank input switches every segment off. Codes 10 to 15 are not digits, so they also switch every segment off.

A phase signal is applied to all seven segment lines after the decode. When the phase is high, every line is inverted. A liquid-crystal readout is driven by applying one square wave both to the phase and to the display's common plane. A lit segment then runs opposite to the common plane, and an unlit segment runs with it. A constant phase of 0 suits common-cathode LEDs, and a constant phase of 1 suits common-anode LEDs.

The square wave can come from outside, or from an on-chip divider. The divider is a two-state machine: state PH_LO drives phase 0 and state PH_HI drives phase 1. Its one transition, PH_LO to PH_HI or PH_HI to PH_LO, fires when the dwell counter reaches HALF_DIV-1. At that point the counter restarts from zero. Reset puts the machine in PH_LO with the counter at zero. The phase that is applied also leaves the block on `bp_out`, and it is registered in step with the segments.

Top module: `bcd_seg_driver`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all segment outputs, `bp_out` and the held code to 0. It also puts the divider in PH_LO with its counter at zero.
- R2: While `pass_en` is 1, the code on `code_in` is decoded and appears on `seg_out` one clock edge later.
- R3: While `pass_en` is 0, the block decodes the code it sampled at the last clock edge where `pass_en` was 1. Changes on `code_in` have no effect on `seg_out`.
- R4: `seg_out` uses bit 0 for segment a, bit 1 for b, and so on up to bit 6 for g. With phase 0, the pattern for each digit is: 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D (segment a lit), 7=0x07, 8=0x7F and 9=0x6F (segment d lit).
- R5: Codes 10 to 15 turn all seven segments off.
- R6: `blank_in` high turns all segments off. It does not change the held code, so the held digit shows again once blanking is released.
- R7: When the applied phase is 1, each of the seven segment bits is the inverse of its phase-0 value. This includes blanked and illegal codes, which give 0x7F.
- R8: `bp_out` carries the applied phase from the same clock edge that produced `seg_out`. Unlit segments therefore equal `bp_out`, and lit segments equal its inverse.
- R9: The internal divider holds phase 0 for HALF_DIV clocks after reset, then phase 1 for HALF_DIV clocks, and keeps alternating, which gives a 50% duty square wave.
- R10: `use_gen` set to 1 selects the internal divider as the applied phase. `use_gen` set to 0 selects `phase_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| code_in | input | 4 | BCD digit, weighted 8-4-2-1 |
| pass_en | input | 1 | 1: track code_in; 0: hold the stored code |
| blank_in | input | 1 | 1: all segments off |
| phase_in | input | 1 | External phase, used when use_gen is 0 |
| use_gen | input | 1 | 1: use the internal divider as the phase |
| seg_out | output | 7 | Segment lines, bit 0 = a through bit 6 = g |
| bp_out | output | 1 | Applied phase, for the common plane |

## Verification
The bench walks all sixteen codes under both phases. A decode table with a wrong pattern, or one that shows glyphs for codes 10 to 15, would give a mismatched segment byte. While the block holds, the bench keeps changing `code_in` and toggles blanking. A latch that leaks the input, or a blank that clobbers the stored code, would show the wrong digit once blanking is released. In generator mode the bench runs several full periods and checks `bp_out` on every clock. This catches a divider that is off by one, starts in the wrong phase, or lets the common plane drift out of step with the segments. A mid-run reset checks that the divider restarts in PH_LO.

// File: rtl/bcd_seg_pkg.sv
package bcd_seg_pkg;
    localparam int CODE_W = 4;
    localparam int SEG_W  = 7;
    localparam int MAX_DIGIT = 9;

    typedef enum logic {PH_LO = 1'b0, PH_HI = 1'b1} phase_state_t;

    // Segment order: bit0 = a ... bit6 = g, active high before phase.
    function automatic logic [SEG_W-1:0] digit_glyph(input logic [CODE_W-1:0] d);
        logic [SEG_W-1:0] g;
        unique case (d)
            4'd0:    g = 7'h3F;
            4'd1:    g = 7'h06;
            4'd2:    g = 7'h5B;
            4'd3:    g = 7'h4F;
            4'd4:    g = 7'h66;
            4'd5:    g = 7'h6D;
            4'd6:    g = 7'h7D;
            4'd7:    g = 7'h07;
            4'd8:    g = 7'h7F;
            4'd9:    g = 7'h6F;
            default: g = '0;
        endcase
        return g;
    endfunction
endpackage

// File: rtl/bcd_code_hold.sv
module bcd_code_hold
    import bcd_seg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [CODE_W-1:0] code_d,
    output logic [CODE_W-1:0] code_eff
);
    logic [CODE_W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst)          held_q <= '0;
        else if (load_en) held_q <= code_d;
    end

    // Transparent while loading, stored value otherwise.
    assign code_eff = load_en ? code_d : held_q;
endmodule

// File: rtl/bcd_phase_gen.sv
module bcd_phase_gen
    import bcd_seg_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic phase_o
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

    phase_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic wrap;

    assign wrap = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_LO;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        phase_o = 1'b0;
        unique case (state_q)
            PH_LO: begin
                phase_o = 1'b0;
                if (wrap) state_d = PH_HI;
            end
            PH_HI: begin
                phase_o = 1'b1;
                if (wrap) state_d = PH_LO;
            end
        endcase
    end

    a_r9_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
    a_r9_toggle_on_wrap: assert property (@(posedge clk) disable iff (rst)
        (phase_o != $past(phase_o)) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/bcd_seg_driver.sv
module bcd_seg_driver
    import bcd_seg_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       code_in,
    input  logic             pass_en,
    input  logic             blank_in,
    input  logic             phase_in,
    input  logic             use_gen,
    output logic [6:0]       seg_out,
    output logic             bp_out
);
    logic [CODE_W-1:0] code_eff;
    logic              gen_phase;
    logic              phase_app;
    logic [SEG_W-1:0]  lit;
    logic [SEG_W-1:0]  drive;
    logic [SEG_W-1:0]  seg_q;
    logic              bp_q;

    bcd_code_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .load_en  (pass_en),
        .code_d   (code_in),
        .code_eff (code_eff)
    );

    bcd_phase_gen #(.HALF_DIV(HALF_DIV)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .phase_o (gen_phase)
    );

    assign phase_app = use_gen ? gen_phase : phase_in;
    assign lit = (blank_in || (code_eff > CODE_W'(MAX_DIGIT))) ? '0 : digit_glyph(code_eff);

    for (genvar i = 0; i < SEG_W; i++) begin : g_seg_phase
        assign drive[i] = lit[i] ^ phase_app;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q <= '0;
            bp_q  <= 1'b0;
        end else begin
            seg_q <= drive;
            bp_q  <= phase_app;
        end
    end

    assign seg_out = seg_q;
    assign bp_out  = bp_q;

    a_r6_blank_tracks_bp: assert property (@(posedge clk) disable iff (rst)
        blank_in |=> (seg_out == {SEG_W{bp_out}}));
    a_r5_illegal_dark: assert property (@(posedge clk) disable iff (rst)
        (pass_en && code_in > 4'd9) |=> (seg_out == {SEG_W{bp_out}}));
    a_r10_ext_phase: assert property (@(posedge clk) disable iff (rst)
        !use_gen |=> (bp_out == $past(phase_in)));
    a_r3_hold_steady: assert property (@(posedge clk) disable iff (rst)
        (!pass_en && !$past(pass_en) && !blank_in && !$past(blank_in)
         && !use_gen && !$past(use_gen) && (phase_in == $past(phase_in)))
        |=> $stable(seg_out));
endmodule

// File: tb/bcd_seg_driver_tb.sv
module bcd_seg_driver_tb;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] code_in = '0;
    logic       pass_en = 1'b0;
    logic       blank_in = 1'b0;
    logic       phase_in = 1'b0;
    logic       use_gen = 1'b0;
    logic [6:0] seg_out;
    logic       bp_out;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";

    // reference model state
    logic [3:0] m_held = '0;
    int         m_cnt = 0;
    logic       m_ph = 1'b0;
    logic [6:0] exp_seg = '0;
    logic       exp_bp = 1'b0;
    bit         exp_valid = 1'b0;

    always #4 clk = ~clk;

    bcd_seg_driver #(.HALF_DIV(HALF)) u_dut (
        .clk(clk), .rst(rst), .code_in(code_in), .pass_en(pass_en),
        .blank_in(blank_in), .phase_in(phase_in), .use_gen(use_gen),
        .seg_out(seg_out), .bp_out(bp_out)
    );

    function automatic logic [6:0] glyph_ref(input int d);
        case (d)
            0: return 7'b0111111;
            1: return 7'b0000110;
            2: return 7'b1011011;
            3: return 7'b1001111;
            4: return 7'b1100110;
            5: return 7'b1101101;
            6: return 7'b1111101;
            7: return 7'b0000111;
            8: return 7'b1111111;
            9: return 7'b1101111;
            default: return 7'b0000000;
        endcase
    endfunction

    task automatic compare();
        if (!exp_valid) return;
        n_cmp++;
        if (seg_out !== exp_seg) begin
            n_bad++;
            $display("FAIL %s seg_out actual=%h expected=%h", cur_req, seg_out, exp_seg);
        end
        n_cmp++;
        if (bp_out !== exp_bp) begin
            n_bad++;
            $display("FAIL R8 (%s) bp_out actual=%b expected=%b", cur_req, bp_out, exp_bp);
        end
    endtask

    // One clock: check last expectation, drive inputs, predict next edge.
    task automatic cyc(input logic r, input logic [3:0] c, input logic p,
                       input logic b, input logic ph, input logic ug);
        logic [3:0] eff;
        logic       ap;
        logic [6:0] l;
        @(negedge clk);
        compare();
        rst = r; code_in = c; pass_en = p; blank_in = b; phase_in = ph; use_gen = ug;
        if (r) begin
            m_held = '0; m_cnt = 0; m_ph = 1'b0;
            exp_seg = '0; exp_bp = 1'b0;
        end else begin
            eff = p ? c : m_held;
            if (p) m_held = c;
            ap = ug ? m_ph : ph;
            l = b ? 7'd0 : glyph_ref(int'(eff));
            exp_seg = l ^ {7{ap}};
            exp_bp = ap;
            if (m_cnt == HALF - 1) begin m_cnt = 0; m_ph = ~m_ph; end
            else m_cnt++;
        end
        exp_valid = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cur_req = "R1";
        for (int i = 0; i < 3; i++) cyc(1, 4'd5, 1, 0, 1, 0);
        // R1 reset state checked at the next compare
        cyc(0, 4'd0, 0, 0, 0, 0);

        // R2 R4 R5: all codes, phase 0, transparent
        for (int c = 0; c < 16; c++) begin
            cur_req = (c > 9) ? "R5" : "R4";
            cyc(0, 4'(c), 1, 0, 0, 0);
        end
        cur_req = "R2";
        cyc(0, 4'd3, 1, 0, 0, 0);
        // R7: all codes, phase 1
        for (int c = 0; c < 16; c++) begin
            cur_req = "R7";
            cyc(0, 4'(c), 1, 0, 1, 0);
        end
        // R3: hold while input moves
        cur_req = "R3";
        cyc(0, 4'd7, 1, 0, 0, 0);
        for (int c = 0; c < 6; c++) cyc(0, 4'(c), 0, 0, 0, 0);
        cyc(0, 4'd12, 0, 0, 1, 0);
        // R6: blank while holding and while passing, held code survives
        cur_req = "R6";
        cyc(0, 4'd2, 0, 1, 0, 0);
        cyc(0, 4'd1, 0, 1, 1, 0);
        cyc(0, 4'd4, 0, 0, 0, 0);
        cyc(0, 4'd9, 1, 1, 0, 0);
        cyc(0, 4'd6, 0, 0, 0, 0);
        cyc(0, 4'd6, 0, 0, 1, 0);
        // R10: external phase pattern
        cur_req = "R10";
        for (int k = 0; k < 12; k++) cyc(0, 4'(k % 10), 1, 0, logic'((k * 5) % 3 == 1), 0);
        // R9: internal divider after a fresh reset
        cur_req = "R1";
        cyc(1, 4'd8, 1, 0, 1, 1);
        cyc(1, 4'd8, 1, 0, 1, 1);
        cur_req = "R9";
        for (int k = 0; k < 5 * 2 * HALF; k++)
            cyc(0, 4'(k % 16), logic'(k % 7 != 3), logic'(k % 11 == 5), 1, 1);
        // R10: switch back to external with divider running
        cur_req = "R10";
        for (int k = 0; k < 6; k++) cyc(0, 4'd8, 1, 0, logic'(k % 2), 0);
        cyc(0, 4'd8, 1, 0, 0, 0);
        @(negedge clk);
        compare();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule